// File: doc/BRIEF.md
# Key-Protected Power Mode Controller

This block owns the power-control value of a chip: an operating mode and a core clock divide setting. A new value is written over a small register bus (address, data, write strobe). It is taken only when the write to the control address sits between two fixed key writes, so one stray store cannot put the chip into a low-power state. From the held mode, the block drives enables for five power domains: core clock, peripheral clock, PLL, crystal/timer domain and external interrupt inputs. It also produces a clock enable that divides the core clock by a power of two.

Each low-power mode switches off a strictly nested set of domains. An enabled interrupt request in any low-power mode starts a wake phase. The wake phase is short after pause or nap. It is long after sleep or stop, because the oscillator has to restart. At the end of the wake phase the block returns to active mode.

The key sequencer has the states `KS_IDLE`, `KS_ARMED` and `KS_STAGED`. A correct first key moves any state to `KS_ARMED` (arm). A control write in `KS_ARMED` moves to `KS_STAGED` (stage). A second-key write in `KS_STAGED` returns to `KS_IDLE` and commits if the key value and mode are good (commit). Any other write to the three addresses returns to `KS_IDLE` (abort). The power machine has the states `PS_ACTIVE`, `PS_LOW` and `PS_WAKE`. `PS_ACTIVE` moves to `PS_LOW` on a commit with a non-zero mode (enter). `PS_LOW` moves to `PS_WAKE` on an enabled interrupt (wake). `PS_WAKE` moves to `PS_ACTIVE` when its count expires (release).

Top module: `pwr_mode_ctrl`

## Requirements
- R1: The control value changes only after three writes in this order: 0x01 to address 0, then the new value to address 1, then 0xF4 to address 2. The new value appears on `ctrl_value` after the clock edge that samples the address-2 write. `ctrl_value` holds the mode in bits 6:4 and the divide setting in bits 2:0. Bits 7 and 3 read as zero.
- R2: A write to address 0, 1 or 2 that is not the expected next step aborts the sequence, and the control value is kept. A write of 0x01 to address 0 always restarts the sequence. Writes to other addresses neither advance nor abort it.
- R3: A staged value whose mode field is 5, 6 or 7 is discarded entirely, including its divide setting.
- R4: The mode codes are 0 active, 1 pause, 2 nap, 3 sleep and 4 stop. Active enables all five domains. Pause turns off the core. Nap also turns off the peripherals. Sleep also turns off the PLL. Stop leaves only the interrupt inputs on.
- R5: While the core is enabled, `core_tick` is high once every 2^CD cycles. The first pulse comes in the first cycle after an accepted commit or after the core turns on. `core_tick` is never high while the core is off.
- R6: In pause, nap, sleep or stop, any `irq_req` bit whose `irq_en` bit is set starts a wake phase. The phase lasts WAKE_SHORT cycles after pause or nap, and WAKE_LONG cycles after sleep or stop. During the phase every domain except the core is on. Afterwards the block is active with mode field 0 and the divide setting kept.
- R7: Commits are accepted only in the active state. A sequence that completes during a low-power or wake state is dropped. When a wake request and a completing sequence fall in the same cycle, the wake proceeds and the sequence is dropped.
- R8: After reset the block is active with control value 0. All domains are on, and `core_tick` is high on every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | base clock |
| rst_n | input | 1 | asynchronous active-low reset |
| bus_addr | input | ADDR_W | register address of a write |
| bus_wdata | input | 8 | write data |
| bus_wr | input | 1 | write strobe, one write per high cycle |
| irq_req | input | N_IRQ | interrupt request lines |
| irq_en | input | N_IRQ | per-line wake enable |
| ctrl_value | output | 8 | held control value (mode 6:4, divide 2:0) |
| en_core | output | 1 | core clock domain enable |
| en_periph | output | 1 | peripheral clock domain enable |
| en_pll | output | 1 | PLL domain enable |
| en_xtal | output | 1 | crystal/timer domain enable |
| en_irq | output | 1 | external interrupt input enable |
| core_tick | output | 1 | divided core clock enable |

## Verification
Two events can fall in the same cycle: the sequencer completing a commit, and the power machine taking a wake request. The bench sets up stop mode and runs the first two steps of a key sequence. It then drives the second-key write in the same cycle that an enabled interrupt rises. After the long wake phase, the control value must show active mode with the old divide setting and no trace of the dropped value. The behavioural model in the bench, compared on every clock, also judges the domain enables and the tick pattern throughout that window.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    localparam int CD_W   = 3;
    localparam int MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        MODE_ACTIVE = 3'd0,
        MODE_PAUSE  = 3'd1,
        MODE_NAP    = 3'd2,
        MODE_SLEEP  = 3'd3,
        MODE_STOP   = 3'd4
    } pmc_mode_e;

    typedef enum logic [1:0] {
        KS_IDLE,
        KS_ARMED,
        KS_STAGED
    } key_state_e;

    typedef enum logic [1:0] {
        PS_ACTIVE,
        PS_LOW,
        PS_WAKE
    } pwr_state_e;

    typedef struct packed {
        logic core;
        logic periph;
        logic pll;
        logic xtal;
        logic irq;
    } dom_en_t;

    function automatic logic mode_is_legal(input logic [MODE_W-1:0] m);
        return m <= MODE_W'(MODE_STOP);
    endfunction

endpackage

// File: rtl/pmc_key_seq.sv
module pmc_key_seq
    import pmc_pkg::*;
#(
    parameter int         ADDR_W    = 4,
    parameter int         KEY1_ADDR = 0,
    parameter int         CTRL_ADDR = 1,
    parameter int         KEY2_ADDR = 2,
    parameter logic [7:0] KEY1_VAL  = 8'h01,
    parameter logic [7:0] KEY2_VAL  = 8'hF4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_wr,
    output logic              commit,
    output logic [MODE_W-1:0] commit_mode,
    output logic [CD_W-1:0]   commit_cd
);

    key_state_e        ks_q, ks_d;
    logic [MODE_W-1:0] stg_mode_q, stg_mode_d;
    logic [CD_W-1:0]   stg_cd_q, stg_cd_d;

    logic hit_k1, hit_ctrl, hit_k2, key1_ok;

    assign hit_k1   = (bus_addr == ADDR_W'(KEY1_ADDR));
    assign hit_ctrl = (bus_addr == ADDR_W'(CTRL_ADDR));
    assign hit_k2   = (bus_addr == ADDR_W'(KEY2_ADDR));
    assign key1_ok  = (bus_wdata == KEY1_VAL);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ks_q       <= KS_IDLE;
            stg_mode_q <= '0;
            stg_cd_q   <= '0;
        end else begin
            ks_q       <= ks_d;
            stg_mode_q <= stg_mode_d;
            stg_cd_q   <= stg_cd_d;
        end
    end

    // next state
    always_comb begin
        ks_d       = ks_q;
        stg_mode_d = stg_mode_q;
        stg_cd_d   = stg_cd_q;
        if (bus_wr) begin
            unique case (ks_q)
                KS_IDLE: begin
                    if (hit_k1 && key1_ok) ks_d = KS_ARMED;
                end
                KS_ARMED: begin
                    if (hit_k1) begin
                        ks_d = key1_ok ? KS_ARMED : KS_IDLE;
                    end else if (hit_ctrl) begin
                        ks_d       = KS_STAGED;
                        stg_mode_d = bus_wdata[6:4];
                        stg_cd_d   = bus_wdata[2:0];
                    end else if (hit_k2) begin
                        ks_d = KS_IDLE;
                    end
                end
                KS_STAGED: begin
                    if (hit_k1) begin
                        ks_d = key1_ok ? KS_ARMED : KS_IDLE;
                    end else if (hit_ctrl || hit_k2) begin
                        ks_d = KS_IDLE;
                    end
                end
                default: ks_d = KS_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        commit      = bus_wr && hit_k2 && (ks_q == KS_STAGED)
                      && (bus_wdata == KEY2_VAL) && mode_is_legal(stg_mode_q);
        commit_mode = stg_mode_q;
        commit_cd   = stg_cd_q;
    end

endmodule

// File: rtl/pmc_power_fsm.sv
module pmc_power_fsm
    import pmc_pkg::*;
#(
    parameter int N_IRQ      = 4,
    parameter int WAKE_SHORT = 4,
    parameter int WAKE_LONG  = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic [MODE_W-1:0] commit_mode,
    input  logic [CD_W-1:0]   commit_cd,
    input  logic [N_IRQ-1:0]  irq_req,
    input  logic [N_IRQ-1:0]  irq_en,
    output pwr_state_e        pstate,
    output logic [MODE_W-1:0] mode,
    output logic [CD_W-1:0]   cd,
    output dom_en_t           dom,
    output logic              accepted
);

    localparam int WMAX   = (WAKE_LONG > WAKE_SHORT) ? WAKE_LONG : WAKE_SHORT;
    localparam int WCNT_W = $clog2(WMAX + 1);

    pwr_state_e        st_q, st_d;
    logic [MODE_W-1:0] mode_q, mode_d;
    logic [CD_W-1:0]   cd_q, cd_d;
    logic [WCNT_W-1:0] wcnt_q, wcnt_d;
    logic              wake_req, deep;

    assign wake_req = |(irq_req & irq_en);
    assign deep     = (mode_q == MODE_W'(MODE_SLEEP)) || (mode_q == MODE_W'(MODE_STOP));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= PS_ACTIVE;
            mode_q <= '0;
            cd_q   <= '0;
            wcnt_q <= '0;
        end else begin
            st_q   <= st_d;
            mode_q <= mode_d;
            cd_q   <= cd_d;
            wcnt_q <= wcnt_d;
        end
    end

    // next state
    always_comb begin
        st_d   = st_q;
        mode_d = mode_q;
        cd_d   = cd_q;
        wcnt_d = wcnt_q;
        unique case (st_q)
            PS_ACTIVE: begin
                if (commit) begin
                    mode_d = commit_mode;
                    cd_d   = commit_cd;
                    if (commit_mode != MODE_W'(MODE_ACTIVE)) st_d = PS_LOW;
                end
            end
            PS_LOW: begin
                if (wake_req) begin
                    st_d   = PS_WAKE;
                    wcnt_d = deep ? WCNT_W'(WAKE_LONG - 1) : WCNT_W'(WAKE_SHORT - 1);
                end
            end
            PS_WAKE: begin
                if (wcnt_q == '0) begin
                    st_d   = PS_ACTIVE;
                    mode_d = MODE_W'(MODE_ACTIVE);
                end else begin
                    wcnt_d = wcnt_q - 1'b1;
                end
            end
            default: st_d = PS_ACTIVE;
        endcase
    end

    // outputs
    always_comb begin
        dom      = '{core: 1'b1, periph: 1'b1, pll: 1'b1, xtal: 1'b1, irq: 1'b1};
        accepted = 1'b0;
        unique case (st_q)
            PS_ACTIVE: accepted = commit;
            PS_LOW: begin
                unique case (mode_q)
                    MODE_W'(MODE_PAUSE): dom.core = 1'b0;
                    MODE_W'(MODE_NAP): begin
                        dom.core   = 1'b0;
                        dom.periph = 1'b0;
                    end
                    MODE_W'(MODE_SLEEP): begin
                        dom.core   = 1'b0;
                        dom.periph = 1'b0;
                        dom.pll    = 1'b0;
                    end
                    MODE_W'(MODE_STOP): begin
                        dom.core   = 1'b0;
                        dom.periph = 1'b0;
                        dom.pll    = 1'b0;
                        dom.xtal   = 1'b0;
                    end
                    default: ;
                endcase
            end
            PS_WAKE: dom.core = 1'b0;
            default: ;
        endcase
    end

    assign pstate = st_q;
    assign mode   = mode_q;
    assign cd     = cd_q;

endmodule

// File: rtl/pmc_core_div.sv
module pmc_core_div
    import pmc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            core_on,
    input  logic            restart,
    input  logic [CD_W-1:0] cd,
    output logic            tick
);

    localparam int DIV_W = (1 << CD_W) - 1;

    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W:0]   mask_w;

    assign mask_w = ((DIV_W + 1)'(1) << cd) - 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 cnt_q <= '0;
        else if (!core_on || restart) cnt_q <= '0;
        else                        cnt_q <= cnt_q + 1'b1;
    end

    assign tick = core_on && ((cnt_q & mask_w[DIV_W-1:0]) == '0);

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pmc_pkg::*;
#(
    parameter int         ADDR_W     = 4,
    parameter int         KEY1_ADDR  = 0,
    parameter int         CTRL_ADDR  = 1,
    parameter int         KEY2_ADDR  = 2,
    parameter logic [7:0] KEY1_VAL   = 8'h01,
    parameter logic [7:0] KEY2_VAL   = 8'hF4,
    parameter int         N_IRQ      = 4,
    parameter int         WAKE_SHORT = 4,
    parameter int         WAKE_LONG  = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_wr,
    input  logic [N_IRQ-1:0]  irq_req,
    input  logic [N_IRQ-1:0]  irq_en,
    output logic [7:0]        ctrl_value,
    output logic              en_core,
    output logic              en_periph,
    output logic              en_pll,
    output logic              en_xtal,
    output logic              en_irq,
    output logic              core_tick
);

    logic              commit;
    logic [MODE_W-1:0] commit_mode;
    logic [CD_W-1:0]   commit_cd;
    pwr_state_e        pstate;
    logic [MODE_W-1:0] mode;
    logic [CD_W-1:0]   cd;
    dom_en_t           dom;
    logic              accepted;

    pmc_key_seq #(
        .ADDR_W   (ADDR_W),
        .KEY1_ADDR(KEY1_ADDR),
        .CTRL_ADDR(CTRL_ADDR),
        .KEY2_ADDR(KEY2_ADDR),
        .KEY1_VAL (KEY1_VAL),
        .KEY2_VAL (KEY2_VAL)
    ) u_key_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_wr     (bus_wr),
        .commit     (commit),
        .commit_mode(commit_mode),
        .commit_cd  (commit_cd)
    );

    pmc_power_fsm #(
        .N_IRQ     (N_IRQ),
        .WAKE_SHORT(WAKE_SHORT),
        .WAKE_LONG (WAKE_LONG)
    ) u_power_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit     (commit),
        .commit_mode(commit_mode),
        .commit_cd  (commit_cd),
        .irq_req    (irq_req),
        .irq_en     (irq_en),
        .pstate     (pstate),
        .mode       (mode),
        .cd         (cd),
        .dom        (dom),
        .accepted   (accepted)
    );

    pmc_core_div u_core_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .core_on(dom.core),
        .restart(accepted),
        .cd     (cd),
        .tick   (core_tick)
    );

    assign ctrl_value = {1'b0, mode, 1'b0, cd};
    assign en_core    = dom.core;
    assign en_periph  = dom.periph;
    assign en_pll     = dom.pll;
    assign en_xtal    = dom.xtal;
    assign en_irq     = dom.irq;

endmodule

// File: rtl/pmc_checker.sv
module pmc_checker
    import pmc_pkg::*;
#(
    parameter int N_IRQ = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_IRQ-1:0] irq_req,
    input logic [N_IRQ-1:0] irq_en,
    input logic [7:0]       ctrl_value,
    input logic             en_core,
    input logic             en_periph,
    input logic             en_pll,
    input logic             en_xtal,
    input logic             en_irq,
    input logic             core_tick,
    input pwr_state_e       pstate,
    input logic             commit
);

    a_r1_change_source: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl_value) |-> ($past(commit) || $past(pstate == PS_WAKE)));

    a_r3_legal_value: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_value[6:4] <= 3'd4) && !ctrl_value[7] && !ctrl_value[3]);

    a_r4_nested_domains: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_core || en_periph) && (!en_periph || en_pll) && (!en_pll || en_xtal) && en_irq);

    a_r4_active_all_on: assert property (@(posedge clk) disable iff (!rst_n)
        (pstate == PS_ACTIVE) |-> (en_core && en_periph && en_pll && en_xtal));

    a_r5_tick_needs_core: assert property (@(posedge clk) disable iff (!rst_n)
        core_tick |-> en_core);

    a_r6_core_held_in_wake: assert property (@(posedge clk) disable iff (!rst_n)
        (pstate == PS_WAKE) |-> (!en_core && en_periph && en_pll && en_xtal));

    a_r6_wake_entry: assert property (@(posedge clk) disable iff (!rst_n)
        ((pstate == PS_LOW) && (|(irq_req & irq_en))) |=> (pstate == PS_WAKE));

    a_r7_low_drops_commit: assert property (@(posedge clk) disable iff (!rst_n)
        ((pstate == PS_LOW) && commit) |=> $stable(ctrl_value));

endmodule

bind pwr_mode_ctrl pmc_checker #(.N_IRQ(N_IRQ)) u_pmc_checker (.*);

// File: tb/test_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module test_pwr_mode_ctrl;

    localparam int WS = 4;
    localparam int WL = 200;
    localparam int NI = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [3:0]    bus_addr = '0;
    logic [7:0]    bus_wdata = '0;
    logic          bus_wr = 1'b0;
    logic [NI-1:0] irq_req = '0;
    logic [NI-1:0] irq_en = '0;
    logic [7:0]    ctrl_value;
    logic          en_core, en_periph, en_pll, en_xtal, en_irq, core_tick;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    pwr_mode_ctrl #(.ADDR_W(4), .N_IRQ(NI), .WAKE_SHORT(WS), .WAKE_LONG(WL)) i_pwr_mode_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .irq_req(irq_req), .irq_en(irq_en), .ctrl_value(ctrl_value),
        .en_core(en_core), .en_periph(en_periph), .en_pll(en_pll), .en_xtal(en_xtal),
        .en_irq(en_irq), .core_tick(core_tick)
    );

    // behavioural reference: 0 active, 1 low, 2 wake
    int         m_state, m_mode, m_cd, m_wcnt, m_div, m_step;
    logic [7:0] m_stage;

    function automatic logic [4:0] exp_dom();
        logic c, p, l, x;
        c = (m_state == 0);
        p = (m_state != 1) || (m_mode < 2);
        l = (m_state != 1) || (m_mode < 3);
        x = (m_state != 1) || (m_mode < 4);
        return {c, p, l, x, 1'b1};
    endfunction

    always @(posedge clk) begin : model
        bit cmt;
        bit core_on;
        if (!rst_n) begin
            m_state = 0; m_mode = 0; m_cd = 0; m_wcnt = 0; m_div = 0; m_step = 0; m_stage = 0;
        end else begin
            cmt = 0;
            core_on = (m_state == 0);
            if (bus_wr) begin
                if (bus_addr == 0) begin
                    m_step = (bus_wdata == 8'h01) ? 1 : 0;
                end else if (bus_addr == 1) begin
                    if (m_step == 1) begin m_stage = bus_wdata; m_step = 2; end
                    else m_step = 0;
                end else if (bus_addr == 2) begin
                    if (m_step == 2 && bus_wdata == 8'hF4 && m_stage[6:4] <= 4) cmt = 1;
                    m_step = 0;
                end
            end
            if (!core_on || (cmt && m_state == 0)) m_div = 0;
            else m_div = (m_div + 1) % 128;
            if (m_state == 0) begin
                if (cmt) begin
                    m_mode = int'(m_stage[6:4]);
                    m_cd = int'(m_stage[2:0]);
                    if (m_mode != 0) m_state = 1;
                end
            end else if (m_state == 1) begin
                if (|(irq_req & irq_en)) begin
                    m_wcnt = (m_mode >= 3) ? WL : WS;
                    m_state = 2;
                end
            end else begin
                m_wcnt--;
                if (m_wcnt == 0) begin m_state = 0; m_mode = 0; end
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // cycle compare, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk((m_state == 2) ? "R6 domains" : "R4 domains",
                {en_core, en_periph, en_pll, en_xtal, en_irq}, exp_dom());
            chk("R5 tick", core_tick,
                int'((m_state == 0) && ((m_div % (1 << m_cd)) == 0)));
            chk("R1 ctrl", ctrl_value, (m_mode << 4) | m_cd);
        end
    end

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic keyed(input logic [7:0] v);
        wr(4'd0, 8'h01); wr(4'd1, v); wr(4'd2, 8'hF4);
        @(negedge clk);
    endtask

    function automatic int doms();
        return {en_core, en_periph, en_pll, en_xtal, en_irq};
    endfunction

    initial begin : watchdog
        #(4 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : stim
        int gap;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8 reset state
        chk("R8 ctrl after reset", ctrl_value, 0);
        chk("R8 domains after reset", doms(), 5'h1F);
        chk("R8 tick after reset", core_tick, 1);

        // R1 active mode with divide 3, then R5 pattern
        keyed(8'h03);
        chk("R1 commit 0x03", ctrl_value, 8'h03);
        repeat (20) @(negedge clk);
        keyed(8'hFB);  // bits 7 and 3 set, mode 7 -> R3 rejected
        chk("R3 illegal mode ignored", ctrl_value, 8'h03);
        keyed(8'h5A);  // mode 5 -> R3 rejected
        chk("R3 mode 5 ignored", ctrl_value, 8'h03);

        // R2 aborts
        wr(0, 8'h01); wr(1, 8'h06); wr(1, 8'h06); wr(2, 8'hF4); @(negedge clk);
        chk("R2 double ctrl write aborts", ctrl_value, 8'h03);
        wr(0, 8'h02); wr(1, 8'h06); wr(2, 8'hF4); @(negedge clk);
        chk("R2 wrong first key aborts", ctrl_value, 8'h03);
        wr(0, 8'h01); wr(1, 8'h06); wr(2, 8'hF5); @(negedge clk);
        chk("R2 wrong second key aborts", ctrl_value, 8'h03);
        wr(0, 8'h01); wr(2, 8'hF4); @(negedge clk);
        chk("R2 skipped ctrl aborts", ctrl_value, 8'h03);
        wr(0, 8'h01); wr(1, 8'h06); wr(7, 8'h99); wr(2, 8'hF4); @(negedge clk);
        chk("R2 foreign address ignored", ctrl_value, 8'h06);
        wr(0, 8'h01); wr(1, 8'h01); wr(0, 8'h01); wr(1, 8'h00); wr(2, 8'hF4); @(negedge clk);
        chk("R2 restart takes last value", ctrl_value, 8'h00);
        repeat (4) @(negedge clk);

        // R4 nap with divide 7, disabled irq ignored, then R6 short wake
        keyed(8'h27);
        chk("R1 nap value", ctrl_value, 8'h27);
        chk("R4 nap domains", doms(), 5'b00111);
        irq_req = 4'b0010; irq_en = 4'b0001;
        repeat (6) @(negedge clk);
        chk("R6 masked irq keeps nap", doms(), 5'b00111);
        irq_en = 4'b0011;
        gap = 0;
        @(negedge clk);
        while (!en_core && gap < 1000) begin gap++; @(negedge clk); end
        chk("R6 short wake length", gap, WS);
        chk("R6 back to active keeps divide", ctrl_value, 8'h07);
        irq_req = '0;
        repeat (300) @(negedge clk);

        // R4 pause
        keyed(8'h11);
        chk("R4 pause domains", doms(), 5'b01111);
        irq_req = 4'b0001;
        repeat (WS + 3) @(negedge clk);
        irq_req = '0;
        chk("R6 pause woke", ctrl_value, 8'h01);

        // R4 sleep, R7 commit dropped while low, R6 long wake
        keyed(8'h32);
        chk("R4 sleep domains", doms(), 5'b00011);
        keyed(8'h00);
        chk("R7 commit in sleep dropped", ctrl_value, 8'h32);
        irq_req = 4'b0001;
        gap = 0;
        @(negedge clk);
        while (!en_core && gap < 1000) begin gap++; @(negedge clk); end
        chk("R6 long wake length", gap, WL);
        irq_req = '0;
        chk("R6 after sleep", ctrl_value, 8'h02);

        // R4 stop, R7 same-cycle wake and commit
        keyed(8'h44);
        chk("R4 stop domains", doms(), 5'b00001);
        wr(0, 8'h01); wr(1, 8'h05);
        bus_addr = 4'd2; bus_wdata = 8'hF4; bus_wr = 1'b1; irq_req = 4'b0001;
        @(negedge clk);
        bus_wr = 1'b0;
        chk("R7 wake wins same cycle", doms(), 5'b01111);
        repeat (WL + 5) @(negedge clk);
        irq_req = '0;
        chk("R7 dropped value absent", ctrl_value, 8'h04);
        repeat (10) @(negedge clk);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule